// File: doc/BRIEF.md
# Three-Step Combination Lock Controller

This block is a synchronous lock sequencer. It holds three secret code values, each loaded through a small programming port. The door is released only when a user enters those three values in order. A value counts as entered in every cycle that a strobe accompanies it on the entry bus. The sequencer names the stored code for the current step on a one-hot select. The value on the entry bus is compared with that code.

A wrong entry at any step drops the sequencer into a failure state and raises an error flag. The open state holds in the same way. Neither state can be left except by the reset. The reset returns the sequencer to the first step. It does not touch the stored code values, so the same combination stays valid from one attempt to the next.

The step states use a one-hot encoding. The open state is the single top bit, and the failure state is all zeros. The step select is the low part of the state vector and the door output is its top bit, so the outputs need no decoding logic.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to the first step. It shows `digit_sel`=001, `door_open`=0 and `err_flag`=0 after that edge, whatever `key_new` and `key_val` carry in that cycle.
- R2: In any step state, a cycle with `key_new` low leaves `digit_sel`, `door_open` and `err_flag` unchanged.
- R3: In any step state, a cycle with `key_new` high and `key_val` different from the selected code moves to the failure state. After that edge the outputs read `err_flag`=1, `door_open`=0 and `digit_sel`=000.
- R4: A cycle with `key_new` high and a matching value advances the step. `digit_sel` goes 001 → 010 → 100, and a match at step 100 opens the door.
- R5: `door_open` is 1 only in the open state. In that state `digit_sel` is 000 and `err_flag` is 0.
- R6: The open and failure states hold on every cycle until the reset, whatever `key_new` and `key_val` carry.
- R7: A write with `prog_we`=1 stores `prog_data` in code 1, 2 or 3 for `prog_idx` 0, 1 or 2. A write to index 3 changes no code. The reset leaves every code unchanged.
- R8: When a code is written in the same cycle that an entry is compared against it, the comparison uses the value held before the write. The new value applies from the next cycle on.
- R9: If `key_new` stays high for several cycles, each cycle is a separate entry, compared against the step that is current in that cycle.
- R10: Exactly one of these holds in every cycle: one bit of `digit_sel` is set, `door_open` is set, or `err_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset, returns the lock to the first step |
| prog_we | input | 1 | Code write enable |
| prog_idx | input | 2 | Code slot index (0..2 valid) |
| prog_data | input | 4 | Code value to store |
| key_new | input | 1 | Entry strobe, one entry per high cycle |
| key_val | input | 4 | Entered value |
| digit_sel | output | 3 | One-hot select of the code compared at the current step |
| door_open | output | 1 | High when the lock is open |
| err_flag | output | 1 | High while the lock sits in the failure state |

## Verification
Two pairs of functions can land on the same edge.

The first pair is the reset and an entry. The bench drives `rst_n` low during a strobe that carries the correct value for the current step. The lock must go back to the first step rather than advance.

The second pair is a code write and a comparison against the same slot. The bench rewrites code 2 in the very cycle it enters the old code 2 value. The old value must be accepted, and a later attempt must need the new value.

A behavioural reference model with its own code array and step counter judges every cycle. Directed checks pin the expected outputs at each of these collisions.

// File: rtl/lock_pkg.sv
`timescale 1ns/1ps
// Package lock_pkg
// Shared defaults for the combination lock. Holds the default code width and
// step count, and a helper that gives the index width for a step count.
package lock_pkg;
    localparam int unsigned KEY_W_DEF = 4;
    localparam int unsigned STEPS_DEF = 3;

    // Width of a slot index for a given number of code slots (at least 1).
    function automatic int unsigned idx_width(input int unsigned steps);
        return (steps > 1) ? $clog2(steps) : 1;
    endfunction
endpackage

// File: rtl/lock_code_bank.sv
`timescale 1ns/1ps
// Module lock_code_bank
// Holds one code register per step and muxes the selected code out.
// Assumes sel is one-hot or zero. A write to an index with no slot is dropped.
// The registers have no reset: codes outlive a lock reset by design.
module lock_code_bank #(
    parameter int unsigned KEY_W = lock_pkg::KEY_W_DEF,
    parameter int unsigned STEPS = lock_pkg::STEPS_DEF,
    parameter int unsigned IDX_W = lock_pkg::idx_width(STEPS)
) (
    input  logic             clk,
    input  logic             prog_we,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [KEY_W-1:0] prog_data,
    input  logic [STEPS-1:0] sel,
    output logic [KEY_W-1:0] code_sel
);
    logic [STEPS*KEY_W-1:0] codes_flat;

    for (genvar g = 0; g < STEPS; g++) begin : g_slot
        logic [KEY_W-1:0] slot_q;
        // Load this slot when its index is written.
        always_ff @(posedge clk) begin
            if (prog_we && (prog_idx == IDX_W'(g))) begin
                slot_q <= prog_data;
            end
        end
        assign codes_flat[g*KEY_W +: KEY_W] = slot_q;
    end

    // AND-OR mux: pick the slot flagged by the one-hot select.
    always_comb begin
        code_sel = '0;
        for (int i = 0; i < STEPS; i++) begin
            if (sel[i]) begin
                code_sel = code_sel | codes_flat[i*KEY_W +: KEY_W];
            end
        end
    end
endmodule

// File: rtl/lock_match.sv
`timescale 1ns/1ps
// Module lock_match
// Equality comparator between the entered value and the selected code.
// Reports a hit only while some step is selected, so that the open and
// failure states can never register a match.
module lock_match #(
    parameter int unsigned KEY_W = lock_pkg::KEY_W_DEF,
    parameter int unsigned STEPS = lock_pkg::STEPS_DEF
) (
    input  logic [KEY_W-1:0] key_val,
    input  logic [KEY_W-1:0] code_sel,
    input  logic [STEPS-1:0] sel,
    output logic             hit
);
    // Compare, gated by an active step.
    always_comb begin
        hit = (|sel) && (key_val == code_sel);
    end
endmodule

// File: rtl/lock_seq_fsm.sv
`timescale 1ns/1ps
// Module lock_seq_fsm
// Step sequencer. The state vector has STEPS+1 bits. A step state has one low
// bit set, the open state has only the top bit set, and the failure state is
// all zeros. A match shifts the state left, so a match at the last step lands
// on the open bit. A miss clears the vector. The open and failure states have
// no low bit set, so they ignore entries. The reset wins over every input.
// Assumes hit is already gated to step states.
module lock_seq_fsm #(
    parameter int unsigned STEPS = lock_pkg::STEPS_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_new,
    input  logic         hit,
    output logic [STEPS:0] state,
    output logic         err_sticky
);
    localparam int unsigned STATE_W = STEPS + 1;
    localparam logic [STATE_W-1:0] FIRST_STEP = STATE_W'(1);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic               in_step;
    logic               err_q;

    assign in_step = |state_q[STEPS-1:0];

    // Next-state: reset, then advance or fail on a strobed entry.
    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d = FIRST_STEP;
        end else if (key_new && in_step) begin
            state_d = hit ? (state_q << 1) : '0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Sticky error flag, set by a strobed miss and cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (key_new && in_step && !hit) begin
            err_q <= 1'b1;
        end
    end

    assign state      = state_q;
    assign err_sticky = err_q;
endmodule

// File: rtl/combo_lock_ctrl.sv
`timescale 1ns/1ps
// Module combo_lock_ctrl
// Top of the combination lock: code bank, comparator and step sequencer.
// Outputs are taken straight from state bits: the low bits are the code
// select and the top bit is the door. Reset is synchronous and active low.
module combo_lock_ctrl #(
    parameter int unsigned KEY_W = lock_pkg::KEY_W_DEF,
    parameter int unsigned STEPS = lock_pkg::STEPS_DEF,
    parameter int unsigned IDX_W = lock_pkg::idx_width(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [KEY_W-1:0] prog_data,
    input  logic             key_new,
    input  logic [KEY_W-1:0] key_val,
    output logic [STEPS-1:0] digit_sel,
    output logic             door_open,
    output logic             err_flag
);
    logic [STEPS:0]   state;
    logic [KEY_W-1:0] code_sel;
    logic             code_hit;

    lock_code_bank #(.KEY_W(KEY_W), .STEPS(STEPS), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .prog_we   (prog_we),
        .prog_idx  (prog_idx),
        .prog_data (prog_data),
        .sel       (state[STEPS-1:0]),
        .code_sel  (code_sel)
    );

    lock_match #(.KEY_W(KEY_W), .STEPS(STEPS)) u_match (
        .key_val  (key_val),
        .code_sel (code_sel),
        .sel      (state[STEPS-1:0]),
        .hit      (code_hit)
    );

    lock_seq_fsm #(.STEPS(STEPS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_new    (key_new),
        .hit        (code_hit),
        .state      (state),
        .err_sticky (err_flag)
    );

    assign digit_sel = state[STEPS-1:0];
    assign door_open = state[STEPS];
endmodule

// File: rtl/combo_lock_ctrl_checker.sv
`timescale 1ns/1ps
// Module combo_lock_ctrl_checker
// Temporal checks on the lock outputs and the comparator result, bound to
// combo_lock_ctrl.
module combo_lock_ctrl_checker #(
    parameter int unsigned STEPS = lock_pkg::STEPS_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_new,
    input logic             hit,
    input logic [STEPS-1:0] digit_sel,
    input logic             door_open,
    input logic             err_flag
);
    assert_reset_home_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (digit_sel == STEPS'(1) && !door_open && !err_flag));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|digit_sel) && !key_new) |=> ($stable(digit_sel) && !err_flag && !door_open));

    assert_miss_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|digit_sel) && key_new && !hit) |=> (err_flag && !door_open && digit_sel == '0));

    assert_last_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel[STEPS-1] && key_new && hit) |=> door_open);

    assert_open_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        door_open |-> (digit_sel == '0 && !err_flag));

    assert_open_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        door_open |=> door_open);

    assert_err_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_one_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({door_open, err_flag, digit_sel}) == 1);
endmodule

bind combo_lock_ctrl combo_lock_ctrl_checker #(.STEPS(STEPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_new   (key_new),
    .hit       (code_hit),
    .digit_sel (digit_sel),
    .door_open (door_open),
    .err_flag  (err_flag)
);

// File: tb/combo_lock_ctrl_bench.sv
`timescale 1ns/1ps
module combo_lock_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_we = 1'b0;
    logic [1:0] prog_idx = '0;
    logic [3:0] prog_data = '0;
    logic       key_new = 1'b0;
    logic [3:0] key_val = '0;
    logic [2:0] digit_sel;
    logic       door_open;
    logic       err_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // Reference model: step index 0..2, 3 means open, -1 means failed.
    int       m_step = 0;
    logic [3:0] m_code [3] = '{4'h0, 4'h0, 4'h0};

    always #2.5 clk = ~clk;

    combo_lock_ctrl u_combo_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_idx(prog_idx),
        .prog_data(prog_data), .key_new(key_new), .key_val(key_val),
        .digit_sel(digit_sel), .door_open(door_open), .err_flag(err_flag)
    );

    always @(posedge clk) begin
        if (!rst_n) m_step <= 0;
        else if (m_step >= 0 && m_step < 3 && key_new)
            m_step <= (key_val == m_code[m_step]) ? m_step + 1 : -1;
        if (prog_we && prog_idx < 2'd3) m_code[prog_idx] <= prog_data;
    end

    function automatic logic [2:0] exp_sel(int s);
        return (s >= 0 && s < 3) ? 3'(1 << s) : 3'b000;
    endfunction

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!done && cycles > 2) begin
            checks++;
            if (digit_sel !== exp_sel(m_step) || door_open !== (m_step == 3)
                || err_flag !== (m_step == -1)) begin
                errors++;
                $display("FAIL %s model: got sel=%b open=%b err=%b expected sel=%b open=%b err=%b",
                         cur_req, digit_sel, door_open, err_flag, exp_sel(m_step),
                         m_step == 3, m_step == -1);
            end
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input logic n, input logic [3:0] v);
        key_new = n; key_val = v;
        @(negedge clk);
        key_new = 1'b0;
    endtask

    task automatic prog(input logic [1:0] i, input logic [3:0] d);
        prog_we = 1'b1; prog_idx = i; prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [2:0] s, input logic o, input logic e);
        checks++;
        if (digit_sel !== s || door_open !== o || err_flag !== e) begin
            errors++;
            $display("FAIL %s: got sel=%b open=%b err=%b expected sel=%b open=%b err=%b",
                     tag, digit_sel, door_open, err_flag, s, o, e);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state", 3'b001, 1'b0, 1'b0);
        cur_req = "R7";
        prog(2'd0, 4'h5); prog(2'd1, 4'hA); prog(2'd2, 4'h3);
        prog(2'd3, 4'hF);  // R7: no such slot, must change nothing
        // R2/R4/R5: correct sequence with idle gaps.
        cur_req = "R4";
        cyc(1'b0, 4'h5); chk("R2 idle in step 1", 3'b001, 1'b0, 1'b0);
        cyc(1'b1, 4'h5); chk("R4 step 2", 3'b010, 1'b0, 1'b0);
        cyc(1'b0, 4'h3); chk("R2 idle in step 2", 3'b010, 1'b0, 1'b0);
        cyc(1'b1, 4'hA); chk("R4 step 3", 3'b100, 1'b0, 1'b0);
        cyc(1'b1, 4'h3); chk("R5 open", 3'b000, 1'b1, 1'b0);
        cur_req = "R6";
        cyc(1'b1, 4'h0); cyc(1'b1, 4'h5);
        chk("R6 open holds", 3'b000, 1'b1, 1'b0);
        do_reset(); chk("R1 reset from open", 3'b001, 1'b0, 1'b0);
        // R3: miss at step 1, then failure holds even for correct codes.
        cur_req = "R3";
        cyc(1'b1, 4'h6); chk("R3 miss at step 1", 3'b000, 1'b0, 1'b1);
        cyc(1'b1, 4'h5); cyc(1'b1, 4'hA);
        chk("R6 failure holds", 3'b000, 1'b0, 1'b1);
        do_reset();
        // Miss at the last step.
        cyc(1'b1, 4'h5); cyc(1'b1, 4'hA); cyc(1'b1, 4'h4);
        chk("R3 miss at step 3", 3'b000, 1'b0, 1'b1);
        do_reset();
        // R9: strobe held through three consecutive correct values.
        cur_req = "R9";
        key_new = 1'b1; key_val = 4'h5; @(negedge clk);
        key_val = 4'hA; @(negedge clk);
        key_val = 4'h3; @(negedge clk);
        key_new = 1'b0;
        chk("R9 held strobe opens", 3'b000, 1'b1, 1'b0);
        do_reset();
        key_new = 1'b1; key_val = 4'h5; @(negedge clk); @(negedge clk);
        key_new = 1'b0;
        chk("R9 held strobe repeats entry", 3'b000, 1'b0, 1'b1);
        // R1: reset wins over a correct entry in the same cycle.
        cur_req = "R1";
        do_reset();
        cyc(1'b1, 4'h5);
        rst_n = 1'b0; cyc(1'b1, 4'hA); rst_n = 1'b1;
        chk("R1 reset beats entry", 3'b001, 1'b0, 1'b0);
        // R8: rewrite code 2 while entering its old value.
        cur_req = "R8";
        cyc(1'b1, 4'h5);
        prog_we = 1'b1; prog_idx = 2'd1; prog_data = 4'hC;
        cyc(1'b1, 4'hA); prog_we = 1'b0;
        chk("R8 old code used", 3'b100, 1'b0, 1'b0);
        // R7: codes survive reset; new code 2 is now required.
        cur_req = "R7";
        do_reset();
        cyc(1'b1, 4'h5); cyc(1'b1, 4'hA);
        chk("R7 new code 2 in force", 3'b000, 1'b0, 1'b1);
        do_reset();
        cyc(1'b1, 4'h5); cyc(1'b1, 4'hC); cyc(1'b1, 4'h3);
        chk("R7 codes kept across reset", 3'b000, 1'b1, 1'b0);
        cur_req = "R10";
        do_reset();
        chk("R10 single state after reset", 3'b001, 1'b0, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule